// File: doc/BRIEF.md
# Single-Frame Receive Buffer

This block sits between a network receive port and a DMA engine that pulls received data. An incoming frame arrives as a byte stream marked by start-of-frame and end-of-frame flags on a per-byte valid strobe. The stream carries the payload followed by its four frame check bytes. The buffer stores the whole stream and hands it to the DMA side, so software receives the check bytes together with the payload.

Only one frame can be held at a time. A new frame is taken only while the remaining count is zero. A frame that starts while data is still waiting is thrown away and raises a sticky overrun flag. A frame whose payload exceeds the configured maximum is also thrown away, leaves the buffer empty and raises a sticky oversize flag. Each flag is cleared by writing one to its own bit of a clear input.

The DMA side sees one byte per cycle under a valid/ready handshake. Each accepted byte moves the read position forward by one and lowers the remaining count by one. A last marker goes with the final byte.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset the remaining count is 0, `rx_ready_o` is 1, `dma_valid_o` is 0, and both flags are 0.
- R2: `rx_ready_o` is 1 exactly when the remaining count is 0, and `dma_valid_o` is 1 exactly when the count is non-zero.
- R3: A frame is accepted when its start byte arrives while the count is 0. In the cycle after its end byte, `rem_len_o` equals the number of stream bytes received, which is the payload length plus 4.
- R4: Stored bytes come out in arrival order, starting at position 0. The last four bytes are the check bytes, and `dma_last_o` is 1 only with the final byte.
- R5: Each cycle with `dma_valid_o` and `dma_ready_i` both high consumes one byte. While `dma_ready_i` is low, `dma_data_o` and `rem_len_o` hold.
- R6: A frame whose start byte arrives while the count is non-zero is dropped entirely and `ovr_o` is set. The held frame's count and bytes are unchanged.
- R7: A stream longer than MAX_PAYLOAD+4 bytes is discarded, the count stays 0, and `big_o` is set.
- R8: A stream of exactly MAX_PAYLOAD+4 bytes (1540 by default) is accepted in full.
- R9: The flags are sticky. `clr_i[0]` clears `ovr_o` and `clr_i[1]` clears `big_o`. A set and a clear in the same cycle leave the flag set.
- R10: Bytes with valid high that arrive outside a frame, with no start flag, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Receive byte strobe |
| rx_sof_i | input | 1 | First byte of a frame (qualified by valid) |
| rx_eof_i | input | 1 | Last byte of a frame (qualified by valid) |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Buffer empty, a new frame will be taken |
| dma_valid_o | output | 1 | Byte available to the DMA side |
| dma_ready_i | input | 1 | DMA side takes the byte |
| dma_data_o | output | 8 | Byte at the current read position |
| dma_last_o | output | 1 | Final byte of the stored frame |
| rem_len_o | output | 11 | Bytes still to be drained |
| ovr_o | output | 1 | Sticky overrun flag |
| big_o | output | 1 | Sticky oversize flag |
| clr_i | input | 2 | Write-one-to-clear: bit 0 overrun, bit 1 oversize |

## Verification
The count and the ready signal change one cycle after the end byte is sampled, and the flags change one cycle after the offending byte. A DMA handshake moves the data, the last marker and the count one cycle later. The read path is combinational, so the byte at the new position is visible in that same following cycle. The bench drives on the falling edge and checks on the next falling edge, after exactly one rising edge has passed, so every result is read in the cycle it becomes due. Stall patterns are mixed in to confirm that the outputs hold while ready is low.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int unsigned CRC_BYTES = 4;
  typedef enum logic [1:0] {CAP_IDLE, CAP_BUSY, CAP_DROP} cap_state_e;
endpackage

// File: rtl/rxbuf_capture.sv
module rxbuf_capture
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 1540,
  parameter int unsigned AW    = 11,
  parameter int unsigned LW    = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  input  logic [7:0]    rx_data_i,
  input  logic          empty_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          commit_o,
  output logic [LW-1:0] commit_len_o,
  output logic          ovr_set_o,
  output logic          big_set_o
);
  cap_state_e st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d;

  assign wr_data_o = rx_data_i;

  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    wr_en_o      = 1'b0;
    wr_addr_o    = cnt_q[AW-1:0];
    commit_o     = 1'b0;
    commit_len_o = cnt_q + LW'(1);
    ovr_set_o    = 1'b0;
    big_set_o    = 1'b0;
    if (rx_valid_i) begin
      if (rx_sof_i) begin
        if (empty_i) begin
          wr_en_o      = 1'b1;
          wr_addr_o    = '0;
          cnt_d        = LW'(1);
          commit_len_o = LW'(1);
          commit_o     = rx_eof_i;
          st_d         = rx_eof_i ? CAP_IDLE : CAP_BUSY;
        end else begin
          ovr_set_o = 1'b1;
          st_d      = rx_eof_i ? CAP_IDLE : CAP_DROP;
        end
      end else begin
        unique case (st_q)
          CAP_BUSY: begin
            if (cnt_q == LW'(DEPTH)) begin
              big_set_o = 1'b1;
              st_d      = rx_eof_i ? CAP_IDLE : CAP_DROP;
            end else begin
              wr_en_o  = 1'b1;
              cnt_d    = cnt_q + LW'(1);
              commit_o = rx_eof_i;
              if (rx_eof_i) st_d = CAP_IDLE;
            end
          end
          CAP_DROP: if (rx_eof_i) st_d = CAP_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CAP_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int unsigned DEPTH = 1540,
  parameter int unsigned AW    = 11
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/rxbuf_drain.sv
module rxbuf_drain #(
  parameter int unsigned AW = 11,
  parameter int unsigned LW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic [LW-1:0] commit_len_i,
  input  logic          take_i,
  output logic [LW-1:0] len_o,
  output logic [AW-1:0] pos_o
);
  // commit only happens while len is zero, take only while non-zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o <= '0;
      pos_o <= '0;
    end else if (commit_i) begin
      len_o <= commit_len_i;
      pos_o <= '0;
    end else if (take_i && len_o != '0) begin
      len_o <= len_o - LW'(1);
      pos_o <= pos_o + AW'(1);
    end
  end
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
  import rxbuf_pkg::*;
#(
  parameter int unsigned MAX_PAYLOAD = 1536,
  localparam int unsigned DEPTH = MAX_PAYLOAD + CRC_BYTES,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  input  logic [7:0]    rx_data_i,
  output logic          rx_ready_o,
  output logic          dma_valid_o,
  input  logic          dma_ready_i,
  output logic [7:0]    dma_data_o,
  output logic          dma_last_o,
  output logic [LW-1:0] rem_len_o,
  output logic          ovr_o,
  output logic          big_o,
  input  logic [1:0]    clr_i
);
  logic          wr_en, commit, ovr_set, big_set;
  logic [AW-1:0] wr_addr, pos;
  logic [7:0]    wr_data;
  logic [LW-1:0] commit_len, len;
  logic [1:0]    flag_set, flag_q;

  rxbuf_capture #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_cap (
    .clk_i, .rst_ni, .rx_valid_i, .rx_sof_i, .rx_eof_i, .rx_data_i,
    .empty_i(len == '0), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .commit_o(commit), .commit_len_o(commit_len),
    .ovr_set_o(ovr_set), .big_set_o(big_set)
  );

  rxbuf_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(pos), .rd_data_o(dma_data_o)
  );

  rxbuf_drain #(.AW(AW), .LW(LW)) u_drn (
    .clk_i, .rst_ni, .commit_i(commit), .commit_len_i(commit_len),
    .take_i(dma_ready_i), .len_o(len), .pos_o(pos)
  );

  assign flag_set = {big_set, ovr_set};

  for (genvar g = 0; g < 2; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= flag_set[g] | (flag_q[g] & ~clr_i[g]);
    end
  end

  assign ovr_o       = flag_q[0];
  assign big_o       = flag_q[1];
  assign rem_len_o   = len;
  assign rx_ready_o  = (len == '0);
  assign dma_valid_o = (len != '0);
  assign dma_last_o  = (len == LW'(1));
endmodule

// File: rtl/rx_frame_buf_chk.sv
module rx_frame_buf_chk #(
  parameter int unsigned LW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_ready_o,
  input logic          dma_valid_o,
  input logic          dma_ready_i,
  input logic [7:0]    dma_data_o,
  input logic          dma_last_o,
  input logic [LW-1:0] rem_len_o,
  input logic          ovr_o,
  input logic          big_o,
  input logic [1:0]    clr_i
);
  a_r2_busy_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_o |-> dma_valid_o);

  a_r5_take_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_valid_o && dma_ready_i |=> rem_len_o == $past(rem_len_o) - LW'(1));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_valid_o && !dma_ready_i |=> $stable(rem_len_o) && $stable(dma_data_o));

  a_r4_last_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_valid_o && dma_ready_i && dma_last_o |=> rx_ready_o);

  a_r9_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !clr_i[0] |=> ovr_o);

  a_r9_big_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    big_o && !clr_i[1] |=> big_o);
endmodule

bind rx_frame_buf rx_frame_buf_chk #(.LW(LW)) u_chk (
  .clk_i, .rst_ni, .rx_ready_o, .dma_valid_o, .dma_ready_i, .dma_data_o,
  .dma_last_o, .rem_len_o, .ovr_o, .big_o, .clr_i
);

// File: tb/tb_rx_frame_buf.sv
module tb_rx_frame_buf;
  localparam int MAXP  = 1536;
  localparam int DEPTH = MAXP + 4;
  localparam int NV    = 5;
  localparam int          V_LEN   [NV] = '{1, 4, 7, 64, 5};
  localparam logic [7:0]  V_SEED  [NV] = '{8'h10, 8'h20, 8'h33, 8'hA0, 8'hFE};
  localparam bit          V_STALL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, dma_ready = 0;
  logic [7:0] rx_data = 0;
  logic [1:0] clr = 0;
  logic rx_ready, dma_valid, dma_last, ovr, big;
  logic [7:0] dma_data;
  logic [10:0] rem_len;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rx_frame_buf dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .dma_valid_o(dma_valid), .dma_ready_i(dma_ready), .dma_data_o(dma_data),
    .dma_last_o(dma_last), .rem_len_o(rem_len), .ovr_o(ovr), .big_o(big),
    .clr_i(clr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ends on the negedge after the end byte was sampled
  task automatic send(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1);
      rx_data = seed + 8'(i);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  // call at a negedge; ends on the negedge after the final handshake
  task automatic drain(input int n, input logic [7:0] seed, input bit stall, input string req);
    int k = 0;
    int cyc = 0;
    while (k < n) begin
      check({req, " valid"}, dma_valid, 1);
      check({req, " data"}, dma_data, 32'(8'(seed + 8'(k))));
      check({req, " last"}, dma_last, (k == n - 1) ? 1 : 0);
      check({req, " rem_len"}, rem_len, n - k);
      dma_ready = stall ? cyc[0] : 1'b1;
      if (dma_ready) k++;
      cyc++;
      @(negedge clk);
    end
    dma_ready = 0;
    check({req, " empty after drain"}, rx_ready, 1);
    check({req, " valid low after drain"}, dma_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rem_len", rem_len, 0);
    check("R1 ready", rx_ready, 1);
    check("R1 dma_valid", dma_valid, 0);
    check("R1 ovr", ovr, 0);
    check("R1 big", big, 0);

    // vector table: R3 length, R4 order/last, R5 stall hold, R2 ready/valid
    for (int v = 0; v < NV; v++) begin
      send(V_LEN[v], V_SEED[v]);
      check("R3 length after end byte", rem_len, V_LEN[v]);
      check("R2 ready low when holding", rx_ready, 0);
      drain(V_LEN[v], V_SEED[v], V_STALL[v], "R4/R5 vector");
    end

    // R10 stray bytes outside a frame
    @(negedge clk); rx_valid = 1; rx_data = 8'h55; rx_eof = 1;
    @(negedge clk); rx_valid = 0; rx_eof = 0;
    @(negedge clk);
    check("R10 stray bytes ignored", rem_len, 0);
    check("R10 still ready", rx_ready, 1);

    // R6 overrun keeps held frame
    send(3, 8'h40);
    send(6, 8'h90);
    check("R6 ovr set", ovr, 1);
    check("R6 held count kept", rem_len, 3);
    drain(3, 8'h40, 1'b0, "R6 held bytes");
    // R9 clear
    clr = 2'b01; @(negedge clk); clr = 0;
    check("R9 ovr cleared", ovr, 0);

    // R9 set wins over clear
    send(2, 8'h70);
    @(negedge clk);
    rx_valid = 1; rx_sof = 1; rx_eof = 1; rx_data = 8'h00; clr = 2'b01;
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; clr = 0;
    check("R9 set beats clear", ovr, 1);
    check("R6 count after one-byte overrun", rem_len, 2);
    drain(2, 8'h70, 1'b1, "R6 held bytes 2");
    clr = 2'b01; @(negedge clk); clr = 0;

    // R7 oversize
    send(DEPTH + 1, 8'h01);
    check("R7 big set", big, 1);
    check("R7 buffer empty", rem_len, 0);
    check("R7 ready", rx_ready, 1);
    check("R7 ovr untouched", ovr, 0);
    repeat (2) @(negedge clk);
    check("R9 big sticky", big, 1);
    clr = 2'b01; @(negedge clk); clr = 0;
    check("R9 clr bit0 leaves big", big, 1);
    clr = 2'b10; @(negedge clk); clr = 0;
    check("R9 clr bit1 clears big", big, 0);

    // R8 exact maximum
    send(DEPTH, 8'hC3);
    check("R8 max length", rem_len, DEPTH);
    check("R8 no big", big, 0);
    drain(DEPTH, 8'hC3, 1'b0, "R8 max drain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule